// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake pins: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them to a host as one 8-bit status byte. Each pin first passes through a two-flop synchronizer. The upper nibble of the status byte shows the present level of each line in asserted (active-high) sense. The lower nibble holds one sticky change flag per line. A flag records that its line moved since the host last read the byte.

The host reads the byte in any cycle by raising a one-cycle read strobe. During that cycle the byte still shows the flags. At the clock edge that ends the cycle, all four flags clear. If a line changes at that same edge, its flag stays set, so no event is lost. Three of the lines flag a change in either direction. The ring-indicator line flags only the end of ringing, which is its pin going from low to high. An interrupt request is raised while the interrupt enable is set and any flag is set.

Top module: `modem_status_detect`

## Requirements
- R1: `status[7:4]` = {carrier, ring, data-set-ready, clear-to-send}, each the inverse of its pin. A pin change is driven just after a clock edge. It appears in the upper nibble after the second following rising edge.
- R2: `status[0]` sets when the clear-to-send pin changes level, high to low or low to high.
- R3: `status[1]` sets when the data-set-ready pin changes level in either direction.
- R4: `status[2]` sets only when the ring-indicator pin goes from low to high. A high-to-low change leaves it clear.
- R5: `status[3]` sets when the carrier-detect pin changes level in either direction.
- R6: A set flag stays set for as long as `rdStb` is low, however much time passes. Further changes on other lines add their own flags.
- R7: While `rdStb` is high, `status` shows the flags unchanged. At the rising edge that ends the strobe cycle, all four flags clear.
- R8: A line change that sets its flag at the same edge as a read clear leaves that flag at 1. All other flags clear.
- R9: `irq` is 1 exactly when `intEn` is 1 and at least one flag is set. With `intEn` at 0, `irq` stays 0.
- R10: Reset clears all flags. No flag sets from the synchronizers' reset values, even when pins are held low (asserted) through and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring-indicator pin, active low |
| cdN | input | 1 | Carrier-detect pin, active low |
| rdStb | input | 1 | One-cycle host read strobe |
| intEn | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Line states (upper nibble) and change flags (lower nibble) |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a flag setting because a synchronized line changed, and the read clear. The bench provokes this by changing the clear-to-send pin and then placing the read strobe exactly in the cycle whose closing edge registers that change. A data-set-ready flag is already pending when this happens. The bench then checks that only the clear-to-send flag survives. A checker property also covers the collision. It requires that a read with no synchronized movement leaves all flags clear. It also requires every rising flag to trace back to a real level change on its line.

// File: rtl/msd_pkg.sv
package msd_pkg;
  // Strobes issued by the control section to the datapath each cycle.
  typedef struct packed {
    logic armEdges;    // synchronizer pipeline holds real samples; edges count
    logic clearFlags;  // host read ends this cycle; wipe pending flags
  } msdStrobes_t;
endpackage

// File: rtl/msd_datapath.sv
module msd_datapath
  import msd_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] RISE_ONLY_MASK = 4'b0100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinN,
  input  msdStrobes_t          strobes,
  output logic [NUM_LINES-1:0] lineState,
  output logic [NUM_LINES-1:0] flags,
  output logic                 anyFlag
);
  // Synchronizer chain; reset to the idle (high) pin level.
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] prevLvl;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] flagsQ;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '1;
        else if (s == 0) syncQ[s] <= pinN;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  logic [NUM_LINES-1:0] curLvl;
  assign curLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '1;
    else prevLvl <= curLvl;
  end

  // Per-line edge qualification: either direction, or pin rising only.
  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_edge
      logic pinRise, pinFall;
      assign pinRise = ~prevLvl[i] & curLvl[i];
      assign pinFall = prevLvl[i] & ~curLvl[i];
      if (RISE_ONLY_MASK[i]) begin : g_rise
        assign hit[i] = strobes.armEdges & pinRise;
      end else begin : g_both
        assign hit[i] = strobes.armEdges & (pinRise | pinFall);
      end
    end
  endgenerate

  // New edges win over the read clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else flagsQ <= (flagsQ & ~{NUM_LINES{strobes.clearFlags}}) | hit;
  end

  assign lineState = ~curLvl;
  assign flags     = flagsQ;
  assign anyFlag   = |flagsQ;
endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStb,
  input  logic        intEn,
  input  logic        anyFlag,
  output msdStrobes_t strobes,
  output logic        irq
);
  // Edges count only once both the synchronizer output and its delayed copy
  // hold real pin samples: SYNC_STAGES + 1 edges after reset.
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW = $clog2(WARM + 1);

  logic [CW-1:0] warmCnt;
  logic armed;

  assign armed = (warmCnt == CW'(WARM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (!armed) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    strobes.armEdges   = armed;
    strobes.clearFlags = rdStb;
  end

  assign irq = intEn & anyFlag;
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       cdN,
  input  logic       rdStb,
  input  logic       intEn,
  output logic [7:0] status,
  output logic       irq
);
  localparam int NUM_LINES = 4;
  // Ring indicator (line 2) flags only the end of ringing.
  localparam logic [NUM_LINES-1:0] RISE_ONLY = 4'b0100;

  msdStrobes_t strobes;
  logic [NUM_LINES-1:0] lineState, flags;
  logic anyFlag;

  msd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .intEn(intEn),
    .anyFlag(anyFlag), .strobes(strobes), .irq(irq)
  );

  msd_datapath #(
    .NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES), .RISE_ONLY_MASK(RISE_ONLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinN({cdN, riN, dsrN, ctsN}), .strobes(strobes),
    .lineState(lineState), .flags(flags), .anyFlag(anyFlag)
  );

  assign status = {lineState, flags};
endmodule

// File: rtl/msd_checker.sv
module msd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdStb,
  input logic       intEn,
  input logic [7:0] status,
  input logic       irq
);
  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (status[3:0] == 4'h0); // R10
    end
  end

  AST_CTS_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> ($past(status[4]) != $past(status[4], 2))); // R2

  AST_RI_END_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[2]) |-> (!$past(status[6]) && $past(status[6], 2))); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && $stable(status[7:4])) |=> (status[3:0] == 4'h0)); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEn); // R9

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (intEn && (status[3:0] != 4'h0)) |-> irq); // R9
endmodule

bind modem_status_detect msd_checker u_msd_checker (
  .clk(clk), .rstN(rstN), .rdStb(rdStb), .intEn(intEn),
  .status(status), .irq(irq)
);

// File: tb/modem_status_detect_bench.sv
module modem_status_detect_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsN = 1'b0, dsrN = 1'b0, riN = 1'b0, cdN = 1'b0;
  logic rdStb = 1'b0, intEn = 1'b0;
  logic [7:0] status;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  modem_status_detect u_modem_status_detect (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .cdN(cdN),
    .rdStb(rdStb), .intEn(intEn), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // One-cycle read: byte checked during strobe, flags checked after.
  task automatic doRead(input string req, input logic [7:0] expDuring);
    rdStb = 1'b1;
    #1 chk(req, status, expDuring);
    step(1);
    rdStb = 1'b0;
    chk(req, {4'h0, status[3:0]}, 8'h00);
  endtask

  task automatic testResetLow();
    // R10: pins asserted through reset
    step(3);
    rstN = 1'b1;
    step(8);
    chk("R10 no flag from sync reset", status, 8'hF0);
    chk("R10 irq idle", {7'h0, irq}, 8'h00);
    {cdN, riN, dsrN, ctsN} = 4'hF;
    step(4);
    chk("R4 R2 R3 R5 all release", status, 8'h0F);
    doRead("R7 read clears all", 8'h0F);
  endtask

  task automatic testBothEdges(input int line, input string req);
    logic [3:0] bitSel;
    bitSel = 4'b0001 << line;
    {cdN, riN, dsrN, ctsN} = ~bitSel;
    step(4);
    chk({req, " assert edge"}, status, {bitSel, bitSel});
    doRead({req, " read"}, {bitSel, bitSel});
    {cdN, riN, dsrN, ctsN} = 4'hF;
    step(4);
    chk({req, " release edge"}, status, {4'h0, bitSel});
    doRead({req, " read"}, {4'h0, bitSel});
  endtask

  task automatic testRing();
    riN = 1'b0;
    step(5);
    chk("R4 ring start no flag", status, 8'h40);
    riN = 1'b1;
    step(4);
    chk("R4 ring end flag", status, 8'h04);
    doRead("R7 ring read", 8'h04);
  endtask

  task automatic testSticky();
    ctsN = 1'b0;
    step(24);
    chk("R6 flag held", status, 8'h11);
    dsrN = 1'b0;
    step(4);
    chk("R6 flags accumulate", status, 8'h33);
    ctsN = 1'b1; dsrN = 1'b1;
    step(4);
    doRead("R7 sticky read", 8'h03);
  endtask

  task automatic testIrq();
    intEn = 1'b0;
    cdN = 1'b0;
    step(4);
    chk("R9 disabled irq", {7'h0, irq}, 8'h00);
    intEn = 1'b1;
    #1 chk("R9 enabled irq", {7'h0, irq}, 8'h01);
    doRead("R9 read", 8'h88);
    chk("R9 irq drops", {7'h0, irq}, 8'h00);
    cdN = 1'b1;
    step(4);
    chk("R9 irq again", {7'h0, irq}, 8'h01);
    doRead("R9 read2", 8'h08);
    intEn = 1'b0;
  endtask

  task automatic testCollision();
    dsrN = 1'b0;
    step(5);
    chk("R3 pending before collision", status, 8'h22);
    ctsN = 1'b0;
    step(1);
    chk("R1 not yet visible", {7'h0, status[4]}, 8'h00);
    step(1);
    chk("R1 visible after two edges", {7'h0, status[4]}, 8'h01);
    rdStb = 1'b1;
    step(1);
    rdStb = 1'b0;
    chk("R8 edge survives read", status, 8'h31);
    doRead("R8 cleanup", 8'h31);
    ctsN = 1'b1; dsrN = 1'b1;
    step(5);
    doRead("R8 cleanup2", 8'h03);
  endtask

  initial begin
    chk("R10 flags in reset", {4'h0, status[3:0]}, 8'h00);
    testResetLow();
    testBothEdges(0, "R2 cts");
    testBothEdges(1, "R3 dsr");
    testBothEdges(3, "R5 cd");
    testRing();
    testSticky();
    testIrq();
    testCollision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule